// File: doc/BRIEF.md
# Burst Address Counter with Priority Controls

This block holds the address that one port of a synchronous memory presents to its array decoder. On each rising clock edge the register can take a new address from the external address bus, return to zero, step forward by one, or keep its value. Three active-low controls choose among these actions, and a fixed priority settles any conflict between them. The register output is the address for the current access. After an edge that loads an external address, that same address is used for the access of that cycle.

A host starts a burst by pulsing the strobe with a start address. After that it only holds the step control low, and the counter produces consecutive addresses internally, so the external bus can stay quiet. The clear control returns the counter to address zero from any state. The clear wins over a load. A step request counts only when neither a load nor a clear is requested. When the counter steps past the all-ones address it wraps to zero. The width is set by a parameter: 16 bits addresses a 64K-deep array and 17 bits a 128K-deep one.

Top module: `burst_addr_ctr`

## Requirements
- R1: While reset is asserted, and after it has been released until the first enabled update, the output address is all zeros.
- R2: With strobe_n low and clear_n high at a rising edge, the output after that edge equals ext_addr as sampled at that edge.
- R3: With strobe_n high, clear_n high and step_n low at a rising edge, the output increases by exactly one.
- R4: A low step_n has no effect when strobe_n is low at the same edge: the output is the loaded address, not that address plus one.
- R5: A low step_n has no effect when clear_n is low at the same edge: the output becomes zero.
- R6: clear_n low forces the output to zero even when strobe_n is low at the same edge, whatever ext_addr holds.
- R7: With strobe_n, step_n and clear_n all high, the output keeps its value, and changes on ext_addr have no effect.
- R8: A step from the all-ones address (every one of the ADDR_W bits set) gives all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized inside the block |
| ext_addr | input | ADDR_W | External address, taken when strobe_n is low |
| strobe_n | input | 1 | Active-low load request |
| step_n | input | 1 | Active-low increment request |
| clear_n | input | 1 | Active-low counter clear, highest priority |
| cur_addr | output | ADDR_W | Registered current address sent to the array decoder |

## Verification
The bench builds the counter with ADDR_W set to 5. With that width the all-ones address is only 31 steps from zero, so the wrap to zero can be reached directly from a loaded start point, and random control mixes cover every address value many times. The priority cases are driven as conflicting combinations at the same edge: strobe with step, clear with step, and clear with strobe. A reset in the middle of the run checks that the register clears asynchronously and then starts counting again once the reset release has been synchronized.

// File: rtl/burst_addr_ctr_pkg.sv
package burst_addr_ctr_pkg;

  // Action taken by the address register at the next rising edge.
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_STEP  = 2'd1,
    ACT_LOAD  = 2'd2,
    ACT_CLEAR = 2'd3
  } addr_act_e;

endpackage

// File: rtl/bac_rst_sync.sv
module bac_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/bac_act_decode.sv
module bac_act_decode
  import burst_addr_ctr_pkg::*;
(
  input  logic      strobe_n,
  input  logic      step_n,
  input  logic      clear_n,
  output addr_act_e act
);

  // Priority: clear over load over step over hold.
  always_comb begin
    if (!clear_n) begin
      act = ACT_CLEAR;
    end else if (!strobe_n) begin
      act = ACT_LOAD;
    end else if (!step_n) begin
      act = ACT_STEP;
    end else begin
      act = ACT_HOLD;
    end
  end

endmodule

// File: rtl/bac_next_addr.sv
module bac_next_addr
  import burst_addr_ctr_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  addr_act_e         act,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] nxt_addr,
  output logic              upd_en
);

  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  always_comb begin
    upd_en   = 1'b1;
    nxt_addr = cur_addr;
    unique case (act)
      ACT_CLEAR: nxt_addr = '0;
      ACT_LOAD:  nxt_addr = ext_addr;
      ACT_STEP:  nxt_addr = cur_addr + ONE;  // wraps naturally at all-ones
      default: begin
        upd_en   = 1'b0;
        nxt_addr = cur_addr;
      end
    endcase
  end

endmodule

// File: rtl/bac_addr_reg.sv
module bac_addr_reg #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic [ADDR_W-1:0] nxt_addr,
  output logic [ADDR_W-1:0] addr_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (upd_en) begin
      addr_q <= nxt_addr;
    end
  end

endmodule

// File: rtl/burst_addr_ctr.sv
module burst_addr_ctr
  import burst_addr_ctr_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int RST_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              strobe_n,
  input  logic              step_n,
  input  logic              clear_n,
  output logic [ADDR_W-1:0] cur_addr
);

  logic              rst_sync_n;
  addr_act_e         act;
  logic [ADDR_W-1:0] nxt_addr;
  logic              upd_en;

  bac_rst_sync #(.STAGES(RST_STAGE)) u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  bac_act_decode u_decode (
    .strobe_n(strobe_n),
    .step_n  (step_n),
    .clear_n (clear_n),
    .act     (act)
  );

  bac_next_addr #(.ADDR_W(ADDR_W)) u_next (
    .act     (act),
    .cur_addr(cur_addr),
    .ext_addr(ext_addr),
    .nxt_addr(nxt_addr),
    .upd_en  (upd_en)
  );

  bac_addr_reg #(.ADDR_W(ADDR_W)) u_reg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .upd_en  (upd_en),
    .nxt_addr(nxt_addr),
    .addr_q  (cur_addr)
  );

endmodule

// File: rtl/burst_addr_ctr_chk.sv
module burst_addr_ctr_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] ext_addr,
  input logic              strobe_n,
  input logic              step_n,
  input logic              clear_n,
  input logic [ADDR_W-1:0] cur_addr
);

  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  assert_reset_zero_R1: assert property (@(posedge clk)
    !rst_n |-> cur_addr == '0);

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !strobe_n && clear_n) |=> cur_addr == $past(ext_addr));

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && strobe_n && clear_n && !step_n) |=> cur_addr == $past(cur_addr) + ONE);

  assert_step_masked_by_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !strobe_n && !step_n && clear_n) |=> cur_addr == $past(ext_addr));

  assert_step_masked_by_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !clear_n && !step_n) |=> cur_addr == '0);

  assert_clear_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !clear_n) |=> cur_addr == '0);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && strobe_n && step_n && clear_n) |=> $stable(cur_addr));

  assert_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && strobe_n && clear_n && !step_n && (&cur_addr)) |=> cur_addr == '0);

endmodule

bind burst_addr_ctr burst_addr_ctr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .ext_addr(ext_addr),
  .strobe_n(strobe_n),
  .step_n  (step_n),
  .clear_n (clear_n),
  .cur_addr(cur_addr)
);

// File: tb/burst_addr_ctr_tb.sv
module burst_addr_ctr_tb;

  localparam int W = 5;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] ext_addr;
  logic         strobe_n;
  logic         step_n;
  logic         clear_n;
  logic [W-1:0] cur_addr;

  int n_vec;
  int n_bad;
  logic [W-1:0] model;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];

  burst_addr_ctr #(.ADDR_W(W)) u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .ext_addr(ext_addr),
    .strobe_n(strobe_n),
    .step_n  (step_n),
    .clear_n (clear_n),
    .cur_addr(cur_addr)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [W-1:0] predict(logic [W-1:0] cur, logic [W-1:0] ext,
                                           logic s, logic e, logic c);
    if (!c)      return '0;
    else if (!s) return ext;
    else if (!e) return cur + 1'b1;
    else         return cur;
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: cur_addr=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(string tag, logic [W-1:0] a, logic s, logic e, logic c);
    @(negedge clk);
    ext_addr = a; strobe_n = s; step_n = e; clear_n = c;
    model = predict(model, a, s, e, c);
    exp_q.push_back(model);
    tag_q.push_back(tag);
  endtask

  task automatic idle_drain();
    @(negedge clk);
    strobe_n = 1'b1; step_n = 1'b1; clear_n = 1'b1;
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  // Monitor: compares each registered result just after its edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() != 0) begin
        logic [W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, cur_addr, e);
      end
    end
  end

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: cur_addr=%0h expected=done", cur_addr);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    n_vec = 0; n_bad = 0;
    model = '0;
    rst_n = 1'b0; ext_addr = 5'h1F; strobe_n = 1'b0; step_n = 1'b0; clear_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", cur_addr, '0);
    strobe_n = 1'b1; step_n = 1'b1;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", cur_addr, '0);

    drive("R2", 5'h0A, 1'b0, 1'b1, 1'b1);
    drive("R3", 5'h00, 1'b1, 1'b0, 1'b1);
    drive("R3", 5'h00, 1'b1, 1'b0, 1'b1);
    drive("R3", 5'h11, 1'b1, 1'b0, 1'b1);
    drive("R7", 5'h15, 1'b1, 1'b1, 1'b1);
    drive("R7", 5'h0E, 1'b1, 1'b1, 1'b1);
    drive("R4", 5'h03, 1'b0, 1'b0, 1'b1);
    drive("R4", 5'h1F, 1'b0, 1'b0, 1'b1);
    drive("R5", 5'h07, 1'b1, 1'b0, 1'b0);
    drive("R2", 5'h1C, 1'b0, 1'b1, 1'b1);
    drive("R6", 5'h15, 1'b0, 1'b1, 1'b0);
    drive("R2", 5'h1C, 1'b0, 1'b1, 1'b1);
    drive("R6", 5'h15, 1'b0, 1'b0, 1'b0);
    drive("R2", 5'h1E, 1'b0, 1'b1, 1'b1);
    drive("R3", 5'h00, 1'b1, 1'b0, 1'b1);
    drive("R8", 5'h00, 1'b1, 1'b0, 1'b1);
    drive("R8", 5'h1F, 1'b1, 1'b0, 1'b1);
    for (int i = 0; i < 40; i++) begin
      drive("R3", 5'h00, 1'b1, 1'b0, 1'b1);
    end
    drive("R7", 5'h09, 1'b1, 1'b1, 1'b1);
    for (int i = 0; i < 200; i++) begin
      logic [W-1:0] a;
      logic s, e, c;
      string t;
      a = W'($urandom);
      s = ($urandom % 3) == 0 ? 1'b0 : 1'b1;
      e = ($urandom % 2) == 0 ? 1'b0 : 1'b1;
      c = ($urandom % 6) == 0 ? 1'b0 : 1'b1;
      if (!c)      t = e ? "R6" : "R5";
      else if (!s) t = e ? "R2" : "R4";
      else if (!e) t = (&model) ? "R8" : "R3";
      else         t = "R7";
      drive(t, a, s, e, c);
    end
    idle_drain();

    drive("R2", 5'h13, 1'b0, 1'b1, 1'b1);
    idle_drain();
    #1;
    rst_n = 1'b0;
    #1;
    check("R1", cur_addr, '0);
    @(negedge clk);
    check("R1", cur_addr, '0);
    rst_n = 1'b1;
    model = '0;
    repeat (4) @(negedge clk);
    check("R1", cur_addr, '0);
    drive("R3", 5'h00, 1'b1, 1'b0, 1'b1);
    drive("R3", 5'h00, 1'b1, 1'b0, 1'b1);
    idle_drain();
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule